// File: doc/BRIEF.md
# Ranked Candidate Top-Four Sorter

Twelve sector sources each send three track candidates per bunch crossing. Each candidate is an 18-bit record: a valid flag, a 7-bit quality rank, a 5-bit local azimuth and a 5-bit local pseudorapidity. A source's three records form a 54-bit crossing word. The word crosses its 27-bit link as two halves on a clock that runs at twice the crossing rate. The block reassembles the halves into 36 candidates and picks the four best by rank through two registered selection stages. It then translates each winner's fields through lookup tables and packs it into a fixed 32-bit word.

The block runs on the double-rate clock. The `bx_strobe` input marks the first half of each crossing. A crossing-zero marker travels with the crossing and restarts a 3-bit crossing counter. The four result words and their valid flags appear together with a one-cycle `win_stb`. They stay unchanged until the next crossing's result arrives.

Top module: `cand_top4_sorter`

## Requirements
- R1: The word of source s is taken from `src_bus[27s+26:27s]`. The half sampled on the cycle with `bx_strobe` high forms bits 26:0 of the source's 54-bit crossing word, and the half sampled on the next cycle forms bits 53:27. Candidate c (0..2) sits at bits 18c+17:18c of that word, with valid at bit 17, rank at 16:10, azimuth at 9:5 and pseudorapidity at 4:0.
- R2: Slot 0 of the output holds the eligible candidate with the highest rank, and slots 1 to 3 hold the next best in falling rank order. Valid slots are contiguous from slot 0.
- R3: When ranks are equal, the candidate with the lower global index s*3+c is placed first.
- R4: A candidate whose valid bit is clear, or whose rank is zero, never wins. Any slot that has no winner outputs an all-zero word with its valid flag clear.
- R5: A table addressed by {valid, rank} gives the winner's momentum code and quality code. The momentum code in word bits 12:8 equals rank[6:2], and the quality code in bits 15:13 equals rank[2:0].
- R6: A table addressed by {source id, azimuth} gives the global azimuth in word bits 7:0. Its value is (20*s + azimuth) mod 256.
- R7: A decoder gives the global pseudorapidity in word bits 21:16. Bits 20:16 are the local value, and bit 21 is set for sources 6 to 11.
- R8: Bit 22 of a filled word is 1. Bits 25:23 hold the crossing counter, and bit 26 is the crossing-zero flag. Bits 31:27 are 0. The counter is 0 on a crossing whose `bc0_in` was high on its first half, and on every other crossing it is one more (mod 8) than on the previous crossing. It starts at 0 after reset, so the first crossing without the marker gets 1.
- R9: `win_stb` rises exactly six clock edges after the edge that sampled the first half of a crossing, once for each crossing. The outputs hold between strobes.
- R10: Reset is synchronous and active high. After reset the strobe, the valid flags and all words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_strobe | input | 1 | High on the first half of a crossing |
| bc0_in | input | 1 | Crossing-zero marker, sampled with the first half |
| src_bus | input | 324 | Twelve 27-bit source links |
| win_stb | output | 1 | One-cycle pulse when new results appear |
| win_valid | output | 4 | Valid flag for each output slot |
| win_word | output | 128 | Four 32-bit winner words, slot k at bits 32k+31:32k |

## Verification
The assertions assume that `bx_strobe` is never high on two cycles in a row, so that every crossing occupies two clock cycles. The bench drives each crossing as a strobed half followed by an unstrobed half. It may leave idle cycles between crossings but never overlaps them. The latency assertion also assumes that every strobe is followed by a proper second half. The stimulus mixes directed rank patterns (ties, ineligible candidates, full-scale values, a crossing-zero marker) with random crossings sent back to back.

// File: rtl/cand_sort_pkg.sv
package cand_sort_pkg;
  localparam int RANK_W = 7;
  localparam int PHI_W  = 5;
  localparam int ETA_W  = 5;
  localparam int ID_W   = 4;
  localparam int BX_W   = 3;
  localparam int WORD_W = 32;
  localparam int NSRC   = 12;
  localparam int CPS    = 3;
  localparam int NWIN   = 4;
  localparam int NCAND  = NSRC * CPS;
  localparam int IDX_W  = $clog2(NCAND);
  localparam int CAND_W = 1 + RANK_W + PHI_W + ETA_W;
  localparam int HALF_W = (CPS * CAND_W) / 2;
  localparam int GETA_W = ETA_W + 1;
  localparam int GPHI_W = 8;
  localparam int PTQ_W  = 8;

  typedef struct packed {
    logic              vld;
    logic [RANK_W-1:0] rank;
    logic [PHI_W-1:0]  phi;
    logic [ETA_W-1:0]  eta;
  } cand_t;

  typedef struct packed {
    cand_t            c;
    logic [IDX_W-1:0] idx;
  } entry_t;

  function automatic logic cs_eligible(entry_t e);
    return e.c.vld && (e.c.rank != '0);
  endfunction

  // true when a is ordered ahead of b
  function automatic logic cs_beats(entry_t a, entry_t b);
    if (!cs_eligible(a)) return 1'b0;
    if (!cs_eligible(b)) return 1'b1;
    if (a.c.rank != b.c.rank) return a.c.rank > b.c.rank;
    return a.idx < b.idx;
  endfunction
endpackage

// File: rtl/cs_demux.sv
module cs_demux
  import cand_sort_pkg::*;
#(
  parameter int NS    = NSRC,
  parameter int HW    = HALF_W,
  parameter int CNT_W = BX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bx_strobe,
  input  logic                 bc0_in,
  input  logic [NS*HW-1:0]     src_bus,
  output logic                 cand_vld,
  output logic [NS*2*HW-1:0]   cand_bus,
  output logic [CNT_W-1:0]     bx_tag,
  output logic                 bc0_tag
);
  logic [NS*HW-1:0] half_q;
  logic             phase_q;
  logic             bc0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      half_q   <= '0;
      bc0_q    <= 1'b0;
      cand_vld <= 1'b0;
      cand_bus <= '0;
      bx_tag   <= '0;
      bc0_tag  <= 1'b0;
    end else begin
      phase_q  <= bx_strobe;
      cand_vld <= phase_q;
      if (bx_strobe) begin
        half_q <= src_bus;
        bc0_q  <= bc0_in;
      end
      if (phase_q) begin
        for (int s = 0; s < NS; s++)
          cand_bus[s*2*HW +: 2*HW] <= {src_bus[s*HW +: HW], half_q[s*HW +: HW]};
        bx_tag  <= bc0_q ? '0 : bx_tag + 1'b1;
        bc0_tag <= bc0_q;
      end
    end
  end

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst) bx_strobe |=> !bx_strobe); // R1
  AST_CAND_AFTER_PAIR: assert property (@(posedge clk) disable iff (rst) cand_vld |-> $past(bx_strobe, 2)); // R1
endmodule

// File: rtl/cs_topk.sv
module cs_topk
  import cand_sort_pkg::*;
#(
  parameter int N = 9,
  parameter int K = NWIN
) (
  input  logic             clk,
  input  logic             rst,
  input  entry_t [N-1:0]   in_e,
  output entry_t [K-1:0]   out_e
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  beat [N];
  logic [CW-1:0] cnt  [N];
  entry_t [K-1:0] sel;

  // beat[i][j]: candidate j is ordered ahead of candidate i
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign beat[i][j] = cs_beats(in_e[j], in_e[i]);
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cnt[i] = '0;
      for (int j = 0; j < N; j++)
        cnt[i] = cnt[i] + CW'(beat[i][j]);
    end
  end

  // eligible keys are unique, so each place count picks at most one entry
  always_comb begin
    sel = '0;
    for (int k = 0; k < K; k++)
      for (int i = 0; i < N; i++)
        if (cs_eligible(in_e[i]) && (cnt[i] == CW'(k)))
          sel[k] = entry_t'(sel[k] | in_e[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) out_e <= '0;
    else     out_e <= sel;
  end

  for (genvar k = 0; k < K; k++) begin : g_chk
    AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (rst) !cs_eligible(out_e[k]) |-> (out_e[k] == '0)); // R4
    if (k < K - 1) begin : g_pair
      AST_RANK_ORDER: assert property (@(posedge clk) disable iff (rst) cs_eligible(out_e[k+1]) |-> (cs_eligible(out_e[k]) && out_e[k].c.rank >= out_e[k+1].c.rank)); // R2
      AST_TIE_ORDER: assert property (@(posedge clk) disable iff (rst) (cs_eligible(out_e[k+1]) && out_e[k].c.rank == out_e[k+1].c.rank) |-> (out_e[k].idx < out_e[k+1].idx)); // R3
    end
  end
endmodule

// File: rtl/cs_lut_rom.sv
module cs_lut_rom #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int KIND     = 0,
  parameter int LOW_W    = 5,
  parameter int PHI_STEP = 20
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  localparam int LMASK = (1 << LOW_W) - 1;
  localparam int RW    = AW - 1;

  logic [DW-1:0] mem [DEPTH];

  // KIND 0: {valid, rank} -> {rank[2:0], rank[RW-1:RW-5]}
  // KIND 1: {source, azimuth} -> source*PHI_STEP + azimuth
  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      int v;
      if (KIND == 0) begin
        int r;
        r = a & ((1 << RW) - 1);
        v = ((a >> RW) != 0) ? (((r & 7) << 5) | (r >> (RW - 5))) : 0;
      end else begin
        v = (a >> LOW_W) * PHI_STEP + (a & LMASK);
      end
      mem[a] = DW'(v);
    end
  end

  always_ff @(posedge clk) q <= mem[addr];
endmodule

// File: rtl/cs_xlate.sv
module cs_xlate
  import cand_sort_pkg::*;
#(
  parameter int NW       = NWIN,
  parameter int NS       = NSRC,
  parameter int CP       = CPS,
  parameter int PHI_STEP = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  entry_t [NW-1:0]    win,
  input  logic [BX_W-1:0]    bx_tag,
  input  logic               bc0_tag,
  output logic               out_stb,
  output logic [NW-1:0]      out_valid,
  output logic [NW*WORD_W-1:0] out_word
);
  localparam int SPARE_W = WORD_W - (1 + BX_W + 1 + GETA_W + PTQ_W + GPHI_W);

  logic [PTQ_W-1:0]  ptq_q  [NW];
  logic [GPHI_W-1:0] gphi_q [NW];
  logic [GETA_W-1:0] geta_q [NW];
  logic [NW-1:0]     vld_q;
  logic [BX_W-1:0]   bx_q;
  logic              bc0_q;
  logic              s4_vld;

  for (genvar k = 0; k < NW; k++) begin : g_win
    logic [ID_W-1:0] src_id;
    assign src_id = ID_W'(win[k].idx / IDX_W'(CP));

    cs_lut_rom #(.AW(1 + RANK_W), .DW(PTQ_W), .KIND(0), .LOW_W(PHI_W), .PHI_STEP(PHI_STEP))
      u_ptq (.clk(clk), .addr({win[k].c.vld, win[k].c.rank}), .q(ptq_q[k]));

    cs_lut_rom #(.AW(ID_W + PHI_W), .DW(GPHI_W), .KIND(1), .LOW_W(PHI_W), .PHI_STEP(PHI_STEP))
      u_phi (.clk(clk), .addr({src_id, win[k].c.phi}), .q(gphi_q[k]));

    always_ff @(posedge clk) begin
      if (rst) begin
        geta_q[k] <= '0;
        vld_q[k]  <= 1'b0;
      end else begin
        geta_q[k] <= {(src_id >= ID_W'(NS / 2)), win[k].c.eta};
        vld_q[k]  <= cs_eligible(win[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s4_vld <= 1'b0;
      bx_q   <= '0;
      bc0_q  <= 1'b0;
    end else begin
      s4_vld <= in_vld;
      bx_q   <= bx_tag;
      bc0_q  <= bc0_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_stb   <= 1'b0;
      out_valid <= '0;
      out_word  <= '0;
    end else begin
      out_stb <= s4_vld;
      if (s4_vld) begin
        out_valid <= vld_q;
        for (int k = 0; k < NW; k++)
          out_word[k*WORD_W +: WORD_W] <= vld_q[k]
            ? {{SPARE_W{1'b0}}, bc0_q, bx_q, 1'b1, geta_q[k], ptq_q[k], gphi_q[k]}
            : '0;
      end
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_chk
    AST_SPARE_LOW: assert property (@(posedge clk) disable iff (rst) out_word[k*WORD_W + WORD_W - 1 -: SPARE_W] == '0); // R8
    AST_EMPTY_WORD: assert property (@(posedge clk) disable iff (rst) !out_valid[k] |-> (out_word[k*WORD_W +: WORD_W] == '0)); // R4
  end
endmodule

// File: rtl/cand_top4_sorter.sv
module cand_top4_sorter
  import cand_sort_pkg::*;
#(
  parameter int N_SRC       = NSRC,
  parameter int SRC_PER_GRP = 3,
  parameter int N_WIN       = NWIN,
  parameter int PHI_STEP    = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bx_strobe,
  input  logic                      bc0_in,
  input  logic [N_SRC*HALF_W-1:0]   src_bus,
  output logic                      win_stb,
  output logic [N_WIN-1:0]          win_valid,
  output logic [N_WIN*WORD_W-1:0]   win_word
);
  localparam int NGRP  = N_SRC / SRC_PER_GRP;
  localparam int GRP_N = SRC_PER_GRP * CPS;
  localparam int NC    = N_SRC * CPS;

  logic                     cand_vld;
  logic [N_SRC*2*HALF_W-1:0] cand_bus;
  logic [BX_W-1:0]          bx_s0, bx_s1, bx_s2;
  logic                     bc0_s0, bc0_s1, bc0_s2;
  logic                     s1_vld, s2_vld;

  entry_t [NC-1:0]         all_e;
  entry_t [NGRP*N_WIN-1:0] fin_e;
  entry_t [N_WIN-1:0]      win_e;

  cs_demux #(.NS(N_SRC), .HW(HALF_W), .CNT_W(BX_W)) u_demux (
    .clk(clk), .rst(rst), .bx_strobe(bx_strobe), .bc0_in(bc0_in), .src_bus(src_bus),
    .cand_vld(cand_vld), .cand_bus(cand_bus), .bx_tag(bx_s0), .bc0_tag(bc0_s0)
  );

  always_comb begin
    for (int s = 0; s < N_SRC; s++)
      for (int c = 0; c < CPS; c++) begin
        all_e[s*CPS + c].c   = cand_t'(cand_bus[s*2*HALF_W + c*CAND_W +: CAND_W]);
        all_e[s*CPS + c].idx = IDX_W'(s*CPS + c);
      end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    cs_topk #(.N(GRP_N), .K(N_WIN)) u_grp (
      .clk(clk), .rst(rst), .in_e(all_e[g*GRP_N +: GRP_N]), .out_e(fin_e[g*N_WIN +: N_WIN])
    );
  end

  cs_topk #(.N(NGRP*N_WIN), .K(N_WIN)) u_final (
    .clk(clk), .rst(rst), .in_e(fin_e), .out_e(win_e)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0; s2_vld <= 1'b0;
      bx_s1  <= '0;   bx_s2  <= '0;
      bc0_s1 <= 1'b0; bc0_s2 <= 1'b0;
    end else begin
      s1_vld <= cand_vld; s2_vld <= s1_vld;
      bx_s1  <= bx_s0;    bx_s2  <= bx_s1;
      bc0_s1 <= bc0_s0;   bc0_s2 <= bc0_s1;
    end
  end

  cs_xlate #(.NW(N_WIN), .NS(N_SRC), .CP(CPS), .PHI_STEP(PHI_STEP)) u_xlate (
    .clk(clk), .rst(rst), .in_vld(s2_vld), .win(win_e), .bx_tag(bx_s2), .bc0_tag(bc0_s2),
    .out_stb(win_stb), .out_valid(win_valid), .out_word(win_word)
  );

  AST_STB_LATENCY: assert property (@(posedge clk) disable iff (rst) win_stb |-> $past(bx_strobe, 6)); // R9
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) win_stb |=> !win_stb); // R9
  AST_VALID_CONTIG: assert property (@(posedge clk) disable iff (rst) (win_valid & (win_valid + 1'b1)) == '0); // R2
endmodule

// File: tb/cand_top4_sorter_tb.sv
module cand_top4_sorter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 12;
  localparam int NC  = 36;
  localparam int HW  = 27;
  localparam int LAT = 6;

  logic clk = 1'b0, rst = 1'b1, bx_strobe = 1'b0, bc0_in = 1'b0;
  logic [NS*HW-1:0] src_bus = '0;
  logic         win_stb;
  logic [3:0]   win_valid;
  logic [127:0] win_word;

  cand_top4_sorter u_dut (.clk(clk), .rst(rst), .bx_strobe(bx_strobe), .bc0_in(bc0_in),
    .src_bus(src_bus), .win_stb(win_stb), .win_valid(win_valid), .win_word(win_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [17:0]  cbuf [NC];
  logic [127:0] expw_q [$];
  logic [3:0]   expv_q [$];
  int           t_q    [$];
  string        tag_q  [$];
  int           ref_bx = 0;
  logic [127:0] last_w = '0;
  bit           have_last = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(int i, int bx, bit bc0);
    logic [6:0] rk; logic [4:0] ph, et; int src; logic [7:0] gphi;
    rk = cbuf[i][16:10]; ph = cbuf[i][9:5]; et = cbuf[i][4:0];
    src = i / 3;
    gphi = 8'((src * 20 + ph) % 256);
    return {5'b0, bc0, 3'(bx), 1'b1, (src >= 6), et, rk[2:0], rk[6:2], gphi};
  endfunction

  task automatic drive_xing(input bit bc0, input string tag);
    bit used [NC];
    logic [127:0] ew = '0;
    logic [3:0] ev = '0;
    logic [53:0] w54;
    logic [NS*HW-1:0] h0, h1;
    ref_bx = bc0 ? 0 : (ref_bx + 1) % 8;
    for (int i = 0; i < NC; i++) used[i] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int best = -1;
      for (int i = 0; i < NC; i++)
        if (cbuf[i][17] && cbuf[i][16:10] != 0 && !used[i])
          if (best < 0 || cbuf[i][16:10] > cbuf[best][16:10]) best = i;
      if (best >= 0) begin
        used[best] = 1'b1;
        ev[k] = 1'b1;
        ew[k*32 +: 32] = ref_word(best, ref_bx, bc0);
      end
    end
    for (int s = 0; s < NS; s++) begin
      w54 = {cbuf[s*3+2], cbuf[s*3+1], cbuf[s*3]};
      h0[s*HW +: HW] = w54[26:0];
      h1[s*HW +: HW] = w54[53:27];
    end
    expw_q.push_back(ew); expv_q.push_back(ev); t_q.push_back(cyc); tag_q.push_back(tag);
    bx_strobe = 1'b1; bc0_in = bc0; src_bus = h0;
    @(negedge clk);
    bx_strobe = 1'b0; bc0_in = 1'b0; src_bus = h1;
    @(negedge clk);
  endtask

  function automatic logic [17:0] mk(bit v, int rk);
    return {v, 7'(rk), 5'($urandom), 5'($urandom)};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (win_stb) begin
        if (t_q.size() == 0) begin
          check(1'b0, "R9", "strobe with no crossing pending", 128'(win_stb), 128'(0));
        end else begin
          logic [127:0] ew; logic [3:0] ev; int t0; string tg;
          ew = expw_q.pop_front(); ev = expv_q.pop_front(); t0 = t_q.pop_front(); tg = tag_q.pop_front();
          check(cyc - t0 == LAT, "R9", "latency", 128'(cyc - t0), 128'(LAT));
          check(win_valid == ev, {tg, " R4"}, "valid mask", 128'(win_valid), 128'(ev));
          for (int k = 0; k < 4; k++)
            check(win_word[k*32 +: 32] == ew[k*32 +: 32], tg, $sformatf("slot %0d", k),
                  128'(win_word[k*32 +: 32]), 128'(ew[k*32 +: 32]));
        end
        last_w = win_word; have_last = 1'b1;
      end else if (have_last) begin
        check(win_word == last_w, "R9", "hold between strobes", win_word, last_w);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(win_stb == 1'b0, "R10", "reset strobe", 128'(win_stb), 128'(0));
    check(win_valid == 4'b0, "R10", "reset valid", 128'(win_valid), 128'(0));
    check(win_word == '0, "R10", "reset words", win_word, 128'(0));

    // nothing eligible
    for (int i = 0; i < NC; i++) cbuf[i] = '0;
    drive_xing(1'b0, "R4");
    // ascending distinct ranks
    for (int i = 0; i < NC; i++) cbuf[i] = mk(1'b1, i * 3 + 1);
    drive_xing(1'b0, "R2");
    // all ranks equal
    for (int i = 0; i < NC; i++) cbuf[i] = mk(1'b1, 50);
    drive_xing(1'b0, "R3");
    // mixed ties
    for (int i = 0; i < NC; i++) cbuf[i] = mk(1'b0, 100);
    cbuf[30] = mk(1'b1, 90); cbuf[5] = mk(1'b1, 90); cbuf[20] = mk(1'b1, 90);
    cbuf[7] = mk(1'b1, 90); cbuf[33] = mk(1'b1, 91); cbuf[2] = mk(1'b1, 90);
    drive_xing(1'b0, "R3");
    // only two eligible: valid rank zero and invalid high rank must lose
    for (int i = 0; i < NC; i++) cbuf[i] = (i % 2 == 0) ? mk(1'b1, 0) : mk(1'b0, 127);
    cbuf[13] = mk(1'b1, 3); cbuf[26] = mk(1'b1, 60);
    drive_xing(1'b0, "R4");
    // crossing-zero marker and counter
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NC; i++) cbuf[i] = mk(1'b1, 1 + ($urandom % 127));
      drive_xing(k == 0, "R8");
    end
    // full-scale fields
    for (int i = 0; i < NC; i++) cbuf[i] = {1'b1, 7'd127, 5'd31, 5'd31};
    drive_xing(1'b0, "R5 R6 R7");
    // random traffic with gaps
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < NC; i++) cbuf[i] = mk(($urandom % 4) != 0, $urandom % 128);
      drive_xing(($urandom % 16) == 0, "R1 R5 R6 R7 R8");
      if ($urandom % 4 == 0) repeat (1 + $urandom % 3) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    check(t_q.size() == 0, "R9", "results outstanding", 128'(t_q.size()), 128'(0));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule